// File: doc/BRIEF.md
# Memory-Resident Register File Sequencer

This block gives a very small integer core its general-purpose registers without a register array. The registers are words inside the one SRAM that also holds code and data. Every operand read and every result write is a normal SRAM access. These accesses share a single memory port with instruction fetch and with the core's own load/store traffic.

Within one instruction the sequencer steps through a fixed series of slots: fetch, first source read, second source read, an optional load/store, and the destination write. It grants one requester per cycle and turns register indices into byte addresses relative to a relocatable window base. A register read returns its data one cycle after the grant, tagged with the requester it belongs to. Register zero never reaches the SRAM.

The window base is written through a side port but only takes effect between instructions. Rewriting it selects another bank of registers. A guard input decides whether software loads and stores that land inside the window are allowed or refused. The register-file mode input sets the window to 16 or 32 registers.

Top module: `rfram_seq`

## Requirements
- R1: After reset the window base equals the parameter RESET_BASE (default 0x100), no SRAM access is issued and no request is granted until a fetch is presented.
- R2: A register access for index n uses SRAM byte address base + 4*n. The two low bits of a written base are ignored, so writing 0x203 gives base 0x200.
- R3: At most one request is granted per cycle, in the fixed order fetch, source 1, source 2, load/store, destination. A request presented outside its slot is not granted. After a destination grant, the next grant can only be a fetch.
- R4: A read of register 0 is granted without an SRAM access, and its response carries data 0.
- R5: A write to register 0 is granted and discarded, with no SRAM access.
- R6: Read data is returned in the cycle after the grant, with exactly one of the fetch, source 1, source 2 or load response flags set.
- R7: A base write takes effect only while the sequencer sits between instructions. Register accesses of an instruction already started keep using the old base, and the new base then selects a different register bank.
- R8: Register accesses never raise the load/store fault, even with the guard set.
- R9: With the guard clear, a load/store inside the window is performed with its byte enables unchanged, so a byte store modifies part of a register.
- R10: With the guard set, a load/store inside the window is granted with the fault flag, issues no SRAM access and returns no load response.
- R11: The window covers 64 bytes when the reduced mode input is 1 and 128 bytes when it is 0. Guarded accesses outside the window, above or below, are ordinary accesses.
- R12: When no load/store is requested in its slot, a pending destination write is granted in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Write strobe for the window base |
| base_wdata_i | input | AW | New window base (byte address) |
| rve_i | input | 1 | 1: 16-register window, 0: 32-register window |
| guard_i | input | 1 | 1: software accesses inside the window fault |
| fetch_valid_i | input | 1 | Instruction fetch request |
| fetch_addr_i | input | AW | Fetch byte address |
| fetch_ready_o | output | 1 | Fetch granted |
| rs1_valid_i | input | 1 | First source read request |
| rs1_idx_i | input | IW | First source register index |
| rs1_ready_o | output | 1 | First source read granted |
| rs2_valid_i | input | 1 | Second source read request |
| rs2_idx_i | input | IW | Second source register index |
| rs2_ready_o | output | 1 | Second source read granted |
| ls_valid_i | input | 1 | Load/store request |
| ls_we_i | input | 1 | 1: store, 0: load |
| ls_addr_i | input | AW | Load/store byte address |
| ls_be_i | input | DW/8 | Store byte enables |
| ls_wdata_i | input | DW | Store data |
| ls_ready_o | output | 1 | Load/store granted |
| ls_fault_o | output | 1 | Granted load/store refused by the window guard |
| rd_valid_i | input | 1 | Destination write request |
| rd_idx_i | input | IW | Destination register index |
| rd_wdata_i | input | DW | Destination write data |
| rd_ready_o | output | 1 | Destination write granted |
| rsp_fetch_o | output | 1 | Response data belongs to the fetch |
| rsp_rs1_o | output | 1 | Response data belongs to source 1 |
| rsp_rs2_o | output | 1 | Response data belongs to source 2 |
| rsp_ls_o | output | 1 | Response data belongs to a load |
| rsp_data_o | output | DW | Response data |
| base_o | output | AW | Window base currently in effect |
| mem_req_o | output | 1 | SRAM access strobe |
| mem_we_o | output | 1 | SRAM write |
| mem_addr_o | output | AW | SRAM byte address |
| mem_be_o | output | DW/8 | SRAM byte enables |
| mem_wdata_o | output | DW | SRAM write data |
| mem_rdata_i | input | DW | SRAM read data, one cycle after the access |

## Verification
The assertions watch on every cycle that grants are exclusive and follow a destination grant only with a fetch. They also check that register 0 never produces an SRAM strobe, that a source grant is followed by its response flag, that a refused access stays off the memory port, and that the base holds steady while an instruction is in progress. Only the bench scenarios can show the data side. These cover correct addresses relative to the current base, partial-register byte stores, switching between register banks, and the exact window edges in both register-file modes.

// File: rtl/rfram_pkg.sv
package rfram_pkg;

  typedef enum logic [2:0] {
    PH_FETCH,
    PH_RS1,
    PH_RS2,
    PH_LS,
    PH_RD
  } phase_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_FETCH,
    SRC_RS1,
    SRC_RS2,
    SRC_LS
  } src_e;

endpackage

// File: rtl/rfram_addr_gen.sv
module rfram_addr_gen #(
  parameter int AW = 12,
  parameter int IW = 5,
  parameter int SH = 2
) (
  input  logic [AW-1:0] base_i,
  input  logic [IW-1:0] idx_i,
  output logic [AW-1:0] addr_o
);

  assign addr_o = base_i + (AW'(idx_i) << SH);

endmodule

// File: rtl/rfram_win_chk.sv
module rfram_win_chk #(
  parameter int AW = 12,
  parameter int IW = 5,
  parameter int BW = 4
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rve_i,
  input  logic          guard_i,
  output logic          fault_o
);

  localparam int          NREG_FULL = 1 << IW;
  localparam int          NREG_RED  = NREG_FULL / 2;
  localparam logic [AW:0] WIN_FULL  = (AW+1)'(NREG_FULL * BW);
  localparam logic [AW:0] WIN_RED   = (AW+1)'(NREG_RED * BW);

  logic [AW:0] off;
  logic        hit;

  // negative offset shows up in the extra top bit
  assign off     = {1'b0, addr_i} - {1'b0, base_i};
  assign hit     = !off[AW] && (off < (rve_i ? WIN_RED : WIN_FULL));
  assign fault_o = guard_i && hit;

endmodule

// File: rtl/rfram_base_reg.sv
module rfram_base_reg #(
  parameter int            AW         = 12,
  parameter logic [AW-1:0] RESET_BASE = AW'('h100)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          apply_i,
  output logic [AW-1:0] base_o
);

  logic [AW-1:0] active_q, pend_val_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= RESET_BASE;
      pend_val_q <= RESET_BASE;
      pend_q     <= 1'b0;
    end else begin
      if (apply_i && pend_q) active_q <= pend_val_q;
      if (we_i) begin
        pend_q     <= 1'b1;
        pend_val_q <= wdata_i;
      end else if (apply_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign base_o = active_q & ~AW'(3);

  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(base_o)); // R7

endmodule

// File: rtl/rfram_seq.sv
module rfram_seq
  import rfram_pkg::*;
#(
  parameter int            AW         = 12,
  parameter int            DW         = 32,
  parameter int            IW         = 5,
  parameter logic [AW-1:0] RESET_BASE = AW'('h100)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            base_we_i,
  input  logic [AW-1:0]   base_wdata_i,
  input  logic            rve_i,
  input  logic            guard_i,
  input  logic            fetch_valid_i,
  input  logic [AW-1:0]   fetch_addr_i,
  output logic            fetch_ready_o,
  input  logic            rs1_valid_i,
  input  logic [IW-1:0]   rs1_idx_i,
  output logic            rs1_ready_o,
  input  logic            rs2_valid_i,
  input  logic [IW-1:0]   rs2_idx_i,
  output logic            rs2_ready_o,
  input  logic            ls_valid_i,
  input  logic            ls_we_i,
  input  logic [AW-1:0]   ls_addr_i,
  input  logic [DW/8-1:0] ls_be_i,
  input  logic [DW-1:0]   ls_wdata_i,
  output logic            ls_ready_o,
  output logic            ls_fault_o,
  input  logic            rd_valid_i,
  input  logic [IW-1:0]   rd_idx_i,
  input  logic [DW-1:0]   rd_wdata_i,
  output logic            rd_ready_o,
  output logic            rsp_fetch_o,
  output logic            rsp_rs1_o,
  output logic            rsp_rs2_o,
  output logic            rsp_ls_o,
  output logic [DW-1:0]   rsp_data_o,
  output logic [AW-1:0]   base_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i
);

  localparam int BW    = DW / 8;
  localparam int SH    = $clog2(BW);
  localparam int NPORT = 3;  // rs1, rs2, rd

  phase_e        ph_q, ph_d;
  src_e          rsp_src_q, rsp_src_d;
  logic          rsp_zero_q, rsp_zero_d;
  logic [AW-1:0] base_q;
  logic          win_fault;
  logic          do_rd;
  logic [IW-1:0] idx_a    [NPORT];
  logic [AW-1:0] reg_addr [NPORT];

  assign idx_a[0] = rs1_idx_i;
  assign idx_a[1] = rs2_idx_i;
  assign idx_a[2] = rd_idx_i;

  for (genvar g = 0; g < NPORT; g++) begin : g_agen
    rfram_addr_gen #(.AW(AW), .IW(IW), .SH(SH)) u_agen (
      .base_i (base_q),
      .idx_i  (idx_a[g]),
      .addr_o (reg_addr[g])
    );
  end

  rfram_win_chk #(.AW(AW), .IW(IW), .BW(BW)) u_win (
    .base_i  (base_q),
    .addr_i  (ls_addr_i),
    .rve_i   (rve_i),
    .guard_i (guard_i),
    .fault_o (win_fault)
  );

  // new base only lands between instructions
  rfram_base_reg #(.AW(AW), .RESET_BASE(RESET_BASE)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .apply_i (ph_q == PH_FETCH),
    .base_o  (base_q)
  );

  always_comb begin
    ph_d          = ph_q;
    fetch_ready_o = 1'b0;
    rs1_ready_o   = 1'b0;
    rs2_ready_o   = 1'b0;
    ls_ready_o    = 1'b0;
    ls_fault_o    = 1'b0;
    rd_ready_o    = 1'b0;
    do_rd         = 1'b0;
    mem_req_o     = 1'b0;
    mem_we_o      = 1'b0;
    mem_addr_o    = '0;
    mem_be_o      = '1;
    mem_wdata_o   = '0;
    rsp_src_d     = SRC_NONE;
    rsp_zero_d    = 1'b0;
    unique case (ph_q)
      PH_FETCH: if (fetch_valid_i) begin
        fetch_ready_o = 1'b1;
        mem_req_o     = 1'b1;
        mem_addr_o    = fetch_addr_i;
        rsp_src_d     = SRC_FETCH;
        ph_d          = PH_RS1;
      end
      PH_RS1: if (rs1_valid_i) begin
        rs1_ready_o = 1'b1;
        mem_req_o   = (rs1_idx_i != '0);
        mem_addr_o  = reg_addr[0];
        rsp_src_d   = SRC_RS1;
        rsp_zero_d  = (rs1_idx_i == '0);
        ph_d        = PH_RS2;
      end
      PH_RS2: if (rs2_valid_i) begin
        rs2_ready_o = 1'b1;
        mem_req_o   = (rs2_idx_i != '0);
        mem_addr_o  = reg_addr[1];
        rsp_src_d   = SRC_RS2;
        rsp_zero_d  = (rs2_idx_i == '0);
        ph_d        = PH_LS;
      end
      PH_LS: begin
        if (ls_valid_i) begin
          ls_ready_o  = 1'b1;
          ls_fault_o  = win_fault;
          mem_req_o   = !win_fault;
          mem_we_o    = ls_we_i;
          mem_addr_o  = ls_addr_i;
          mem_be_o    = ls_we_i ? ls_be_i : '1;
          mem_wdata_o = ls_wdata_i;
          rsp_src_d   = (!ls_we_i && !win_fault) ? SRC_LS : SRC_NONE;
          ph_d        = PH_RD;
        end else if (rd_valid_i) begin
          do_rd = 1'b1;
        end
      end
      PH_RD: if (rd_valid_i) do_rd = 1'b1;
      default: ph_d = PH_FETCH;
    endcase
    if (do_rd) begin
      rd_ready_o  = 1'b1;
      mem_req_o   = (rd_idx_i != '0);
      mem_we_o    = 1'b1;
      mem_addr_o  = reg_addr[2];
      mem_wdata_o = rd_wdata_i;
      ph_d        = PH_FETCH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q       <= PH_FETCH;
      rsp_src_q  <= SRC_NONE;
      rsp_zero_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      rsp_src_q  <= rsp_src_d;
      rsp_zero_q <= rsp_zero_d;
    end
  end

  assign rsp_fetch_o = (rsp_src_q == SRC_FETCH);
  assign rsp_rs1_o   = (rsp_src_q == SRC_RS1);
  assign rsp_rs2_o   = (rsp_src_q == SRC_RS2);
  assign rsp_ls_o    = (rsp_src_q == SRC_LS);
  assign rsp_data_o  = rsp_zero_q ? '0 : mem_rdata_i;
  assign base_o      = base_q;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fetch_ready_o, rs1_ready_o, rs2_ready_o, ls_ready_o, rd_ready_o})); // R3

  AST_RD_THEN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |=> !(rs1_ready_o || rs2_ready_o || ls_ready_o || rd_ready_o)); // R3

  AST_X0_READ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rs1_ready_o && rs1_idx_i == '0) || (rs2_ready_o && rs2_idx_i == '0)) |-> !mem_req_o); // R4

  AST_X0_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ready_o && rd_idx_i == '0) |-> !mem_req_o); // R5

  AST_RS1_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs1_ready_o |=> (rsp_rs1_o && !rsp_rs2_o && !rsp_ls_o && !rsp_fetch_o)); // R6

  AST_FAULT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_fault_o |-> (ls_ready_o && guard_i && !mem_req_o)); // R10

  AST_FAULT_NO_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_fault_o |=> !rsp_ls_o); // R10

endmodule

// File: tb/rfram_seq_test.sv
`timescale 1ns/1ps
module rfram_seq_test;

  localparam int AW = 12;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam logic [AW-1:0] RBASE = 12'h100;
  localparam int VW = 3*IW + 3*DW;
  localparam int NV = 6;

  // {rs1, rs2, rd, rd data, expected rs1, expected rs2}
  localparam logic [VW-1:0] VECS [NV] = '{
    {5'd0,  5'd0, 5'd1,  32'h11111111, 32'h00000000, 32'h00000000},
    {5'd1,  5'd0, 5'd2,  32'h22222222, 32'h11111111, 32'h00000000},
    {5'd1,  5'd2, 5'd0,  32'hDEADBEEF, 32'h11111111, 32'h22222222},
    {5'd0,  5'd2, 5'd15, 32'hF0F0F0F0, 32'h00000000, 32'h22222222},
    {5'd15, 5'd1, 5'd31, 32'h31313131, 32'hF0F0F0F0, 32'h11111111},
    {5'd31, 5'd0, 5'd3,  32'h33333333, 32'h31313131, 32'h00000000}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic base_we = 0, rve = 0, guard = 0;
  logic [AW-1:0] base_wdata = '0;
  logic fetch_valid = 0, rs1_valid = 0, rs2_valid = 0, ls_valid = 0, rd_valid = 0;
  logic [AW-1:0] fetch_addr = '0, ls_addr = '0;
  logic [IW-1:0] rs1_idx = '0, rs2_idx = '0, rd_idx = '0;
  logic ls_we = 0;
  logic [3:0] ls_be = '0;
  logic [DW-1:0] ls_wdata = '0, rd_wdata = '0;
  logic fetch_ready, rs1_ready, rs2_ready, ls_ready, ls_fault, rd_ready;
  logic rsp_fetch, rsp_rs1, rsp_rs2, rsp_ls;
  logic [DW-1:0] rsp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] base_o, mem_addr;
  logic mem_req, mem_we;
  logic [3:0] mem_be;
  logic [DW-1:0] mem [1024];

  int checks = 0, fails = 0;
  logic [AW-1:0] exp_base = RBASE;

  always #2.5 clk = ~clk;

  rfram_seq #(.AW(AW), .DW(DW), .IW(IW), .RESET_BASE(RBASE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .base_we_i(base_we), .base_wdata_i(base_wdata),
    .rve_i(rve), .guard_i(guard),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr), .fetch_ready_o(fetch_ready),
    .rs1_valid_i(rs1_valid), .rs1_idx_i(rs1_idx), .rs1_ready_o(rs1_ready),
    .rs2_valid_i(rs2_valid), .rs2_idx_i(rs2_idx), .rs2_ready_o(rs2_ready),
    .ls_valid_i(ls_valid), .ls_we_i(ls_we), .ls_addr_i(ls_addr), .ls_be_i(ls_be),
    .ls_wdata_i(ls_wdata), .ls_ready_o(ls_ready), .ls_fault_o(ls_fault),
    .rd_valid_i(rd_valid), .rd_idx_i(rd_idx), .rd_wdata_i(rd_wdata), .rd_ready_o(rd_ready),
    .rsp_fetch_o(rsp_fetch), .rsp_rs1_o(rsp_rs1), .rsp_rs2_o(rsp_rs2), .rsp_ls_o(rsp_ls),
    .rsp_data_o(rsp_data), .base_o(base_o),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // SRAM model: word k starts as A5000000|k
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 1024; k++) mem[k] <= 32'hA5000000 | k;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic ph_fetch(input logic [AW-1:0] fa);
    fetch_valid = 1; fetch_addr = fa;
    #1;
    chk(fetch_ready && mem_req && !mem_we, "R3 fetch grant", {fetch_ready, mem_req, mem_we}, 3'b110);
    chk(mem_addr == fa, "R3 fetch addr", mem_addr, fa);
    @(posedge clk); @(negedge clk);
    fetch_valid = 0;
    chk(rsp_fetch && rsp_data == (32'hA5000000 | fa[11:2]), "R6 fetch rsp", rsp_data, 32'hA5000000 | fa[11:2]);
  endtask

  task automatic ph_rs(input bit second, input logic [IW-1:0] idx, input logic [31:0] exp);
    logic [AW-1:0] ea;
    ea = exp_base + AW'(idx) * 4;
    if (second) begin rs2_valid = 1; rs2_idx = idx; end
    else        begin rs1_valid = 1; rs1_idx = idx; end
    #1;
    chk(second ? rs2_ready : rs1_ready, "R3 source grant", 0, 1);
    chk(mem_req == (idx != 0), "R4 x0 read no access", mem_req, idx != 0);
    if (idx != 0) chk(mem_addr == ea && !mem_we, "R2 source addr", mem_addr, ea);
    chk(!ls_fault, "R8 no fault on register read", ls_fault, 0);
    @(posedge clk); @(negedge clk);
    rs1_valid = 0; rs2_valid = 0;
    chk((second ? rsp_rs2 : rsp_rs1) && !rsp_fetch && !rsp_ls, "R6 source rsp tag",
        {rsp_fetch, rsp_rs1, rsp_rs2, rsp_ls}, second ? 4'b0010 : 4'b0100);
    chk(rsp_data == exp, idx == 0 ? "R4 x0 data" : "R6 source data", rsp_data, exp);
  endtask

  task automatic ph_ls(input logic we, input logic [AW-1:0] a, input logic [3:0] be,
                       input logic [31:0] wd, input logic exp_fault, input logic [31:0] exp_ld);
    ls_valid = 1; ls_we = we; ls_addr = a; ls_be = be; ls_wdata = wd;
    #1;
    chk(ls_ready, "R3 ls grant", ls_ready, 1);
    chk(ls_fault == exp_fault, exp_fault ? "R10 fault flag" : "R11 no fault", ls_fault, exp_fault);
    chk(mem_req == !exp_fault, "R10 access suppression", mem_req, !exp_fault);
    if (!exp_fault)
      chk(mem_addr == a && mem_we == we && (!we || mem_be == be), "R9 ls passthrough",
          {mem_be, mem_addr}, {be, a});
    @(posedge clk); @(negedge clk);
    ls_valid = 0;
    chk(rsp_ls == (!we && !exp_fault), "R10 load rsp flag", rsp_ls, !we && !exp_fault);
    if (!we && !exp_fault) chk(rsp_data == exp_ld, "R11 load data", rsp_data, exp_ld);
  endtask

  task automatic ph_rd(input logic [IW-1:0] idx, input logic [31:0] wd, input bit after_ls);
    logic [AW-1:0] ea;
    ea = exp_base + AW'(idx) * 4;
    rd_valid = 1; rd_idx = idx; rd_wdata = wd;
    #1;
    chk(rd_ready, after_ls ? "R3 rd grant" : "R12 rd in ls slot", rd_ready, 1);
    chk(mem_req == (idx != 0), "R5 x0 write no access", mem_req, idx != 0);
    if (idx != 0) chk(mem_addr == ea && mem_we && mem_wdata == wd, "R2 rd addr", mem_addr, ea);
    @(posedge clk); @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic insn(input logic [AW-1:0] fa, input logic [IW-1:0] r1, input logic [IW-1:0] r2,
                      input logic [IW-1:0] rd, input logic [31:0] wd,
                      input logic [31:0] e1, input logic [31:0] e2);
    ph_fetch(fa);
    ph_rs(0, r1, e1);
    ph_rs(1, r2, e2);
    ph_rd(rd, wd, 0);
  endtask

  task automatic insn_ls(input logic [AW-1:0] fa, input logic we, input logic [AW-1:0] a,
                         input logic [3:0] be, input logic [31:0] wd,
                         input logic exp_fault, input logic [31:0] exp_ld);
    ph_fetch(fa);
    ph_rs(0, 0, 0);
    ph_rs(1, 0, 0);
    ph_ls(we, a, be, wd, exp_fault, exp_ld);
    ph_rd(0, 0, 1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(base_o == RBASE, "R1 reset base", base_o, RBASE);
    chk(!mem_req && !fetch_ready, "R1 idle after reset", {mem_req, fetch_ready}, 0);
    // R3 out-of-turn requests ignored in fetch slot
    rs1_valid = 1; rd_valid = 1; rs1_idx = 5'd1; rd_idx = 5'd1;
    #1;
    chk(!rs1_ready && !rd_ready && !mem_req, "R3 out of turn", {rs1_ready, rd_ready, mem_req}, 0);
    @(negedge clk);
    rs1_valid = 0; rd_valid = 0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VECS[i];
      insn(AW'(i * 4), v[VW-1 -: IW], v[VW-IW-1 -: IW], v[VW-2*IW-1 -: IW],
           v[3*DW-1 -: DW], v[2*DW-1 -: DW], v[DW-1:0]);
    end

    // R9 byte store into x1 with guard clear
    insn_ls(12'h018, 1, 12'h105, 4'b0010, 32'h0000AB00, 0, 0);
    insn(12'h01C, 5'd1, 5'd0, 5'd0, 0, 32'h1111AB11, 0);
    // R10 guarded load inside window
    guard = 1;
    insn_ls(12'h020, 0, 12'h108, 4'hF, 0, 1, 0);
    // R8 register traffic under guard
    insn(12'h024, 5'd2, 5'd3, 5'd4, 32'h44444444, 32'h22222222, 32'h33333333);
    // R11 window edges
    rve = 1;
    insn_ls(12'h028, 0, 12'h140, 4'hF, 0, 0, 32'hA5000050);
    insn_ls(12'h02C, 0, 12'h13C, 4'hF, 0, 1, 0);
    rve = 0;
    insn_ls(12'h030, 0, 12'h140, 4'hF, 0, 1, 0);
    insn_ls(12'h034, 0, 12'h17C, 4'hF, 0, 1, 0);
    insn_ls(12'h038, 0, 12'h180, 4'hF, 0, 0, 32'hA5000060);
    insn_ls(12'h03C, 0, 12'h0FC, 4'hF, 0, 0, 32'hA500003F);
    guard = 0;

    // R7 base write mid-instruction waits for boundary
    ph_fetch(12'h040);
    base_we = 1; base_wdata = 12'h203;
    ph_rs(0, 5'd1, 32'h1111AB11);
    base_we = 0;
    ph_rs(1, 5'd2, 32'h22222222);
    ph_rd(5'd0, 0, 0);
    chk(base_o == 12'h100, "R7 base held in instruction", base_o, 12'h100);
    @(negedge clk);
    chk(base_o == 12'h200, "R7 base at boundary, R2 low bits dropped", base_o, 12'h200);
    exp_base = 12'h200;
    insn(12'h044, 5'd1, 5'd0, 5'd1, 32'h77777777, 32'hA5000081, 0);
    insn(12'h048, 5'd1, 5'd0, 5'd0, 0, 32'h77777777, 0);
    base_we = 1; base_wdata = 12'h100;
    @(negedge clk);
    base_we = 0;
    @(negedge clk);
    chk(base_o == 12'h100, "R7 base restored", base_o, 12'h100);
    exp_base = 12'h100;
    insn(12'h04C, 5'd1, 5'd2, 5'd0, 0, 32'h1111AB11, 32'h22222222);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule